// File: doc/BRIEF.md
# 4B5B Transmit Framer

This block sits between a media-independent nibble interface and a scrambler in a 100 Mbps twisted-pair transmit path. On every rising edge of the 25 MHz nibble clock it samples a data nibble, a frame-enable strobe and an error strobe. It then emits one 5-bit code group, ready for the scrambler.

The framer is aware of frame boundaries. Between frames it streams idle code groups. It marks the start of a frame by turning the first two preamble nibbles into the start delimiter pair. It translates body nibbles through the 4B5B data table and swaps in the halt code group whenever the error strobe is raised. When the enable strobe falls, it closes the frame with the end delimiter pair. A frame that stops during the start delimiter still gets both delimiter pairs in full.

All code groups in this document are written with bit 4 leftmost. Bit 4 is the first bit that goes to the line.

Top module: `tx_codegroup_framer`

## Requirements
- R1: In a frame body, with `tx_en`=1 and `tx_er`=0, nibble values 0x0 to 0xF produce these code groups in order: 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R2: While no frame is in progress, `code_out` is the idle code group 11111 on every clock.
- R3: A frame starts when `tx_en` is sampled high while the framer is idle. That nibble is sent as 11000 and the next nibble is sent as 10001, whatever the data values.
- R4: After the body, the first nibble sampled with `tx_en`=0 produces 01101. The next clock produces 00111, and after that the output returns to idle.
- R5: In a frame body, a nibble sampled with both `tx_en` and `tx_er` high is sent as 00100 instead of its data code group.
- R6: While `tx_en` is low, and while the end delimiter pair is being sent, `txd` and `tx_er` have no effect on `code_out`.
- R7: Inputs are sampled on the rising clock edge. The code group for a nibble appears on `code_out` after that edge and holds for one clock, so `code_out` does not change between edges.
- R8: `rst` is synchronous and active high. Any edge with `rst` high leaves `code_out` at 11111 and the framer idle, including in the middle of a frame.
- R9: If `tx_en` falls during either nibble of the start delimiter, the framer still sends 11000, 10001, 01101 and 00111 in that order before going idle.
- R10: `tx_er` raised on either start-delimiter nibble does not alter 11000 or 10001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Nibble clock (25 MHz in use) |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Frame enable strobe |
| tx_er | input | 1 | Transmit error strobe |
| txd | input | 4 | Transmit data nibble |
| code_out | output | 5 | Registered code group, bit 4 sent first |

## Verification
The bench builds the framer with the package defaults: a 4-bit nibble and a 5-bit code group. With these values, one long frame can walk through all sixteen data nibbles, and all six control code groups stay reachable. The bench also drives the short cases: a frame that drops enable on its first or second nibble, errors raised on delimiter nibbles and on the last body nibble, and a reset that lands in the middle of a frame.

// File: rtl/cg_pkg.sv
`timescale 1ns/1ps
package cg_pkg;

    localparam int NIB_W = 4;
    localparam int CG_W  = 5;
    localparam int NIB_VALUES = 1 << NIB_W;

    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [CG_W-1:0]  cg_t;

    // control code groups, bit 4 first on the line
    localparam cg_t CG_IDLE = 5'b11111;
    localparam cg_t CG_SSD1 = 5'b11000;
    localparam cg_t CG_SSD2 = 5'b10001;
    localparam cg_t CG_END1 = 5'b01101;
    localparam cg_t CG_END2 = 5'b00111;
    localparam cg_t CG_HALT = 5'b00100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SSD2,
        ST_BODY,
        ST_END1,
        ST_END2
    } fr_state_e;

    typedef struct packed {
        logic en;
        logic er;
        nib_t d;
    } mii_tx_s;

    function automatic cg_t nib_to_cg(input nib_t n);
        cg_t c;
        case (n)
            4'h0: c = 5'b11110;
            4'h1: c = 5'b01001;
            4'h2: c = 5'b10100;
            4'h3: c = 5'b10101;
            4'h4: c = 5'b01010;
            4'h5: c = 5'b01011;
            4'h6: c = 5'b01110;
            4'h7: c = 5'b01111;
            4'h8: c = 5'b10010;
            4'h9: c = 5'b10011;
            4'hA: c = 5'b10110;
            4'hB: c = 5'b10111;
            4'hC: c = 5'b11010;
            4'hD: c = 5'b11011;
            4'hE: c = 5'b11100;
            default: c = 5'b11101;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/cg_data_map.sv
`timescale 1ns/1ps
module cg_data_map
    import cg_pkg::*;
(
    input  nib_t nib,
    output cg_t  code
);
    // R1: pure table translation of a body nibble
    assign code = nib_to_cg(nib);
endmodule

// File: rtl/cg_frame_seq.sv
`timescale 1ns/1ps
module cg_frame_seq
    import cg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  mii_tx_s tx,
    input  cg_t     data_cg,
    output cg_t     cg_nxt
);
    fr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        cg_nxt  = CG_IDLE;
        case (state_q)
            ST_IDLE: begin
                if (tx.en) begin
                    cg_nxt  = CG_SSD1;
                    state_d = ST_SSD2;
                end
            end
            ST_SSD2: begin
                // second delimiter always completes; a dropped enable
                // goes straight to the closing pair
                cg_nxt  = CG_SSD2;
                state_d = tx.en ? ST_BODY : ST_END1;
            end
            ST_BODY: begin
                if (tx.en) begin
                    cg_nxt = tx.er ? CG_HALT : data_cg;
                end else begin
                    cg_nxt  = CG_END1;
                    state_d = ST_END2;
                end
            end
            ST_END1: begin
                cg_nxt  = CG_END1;
                state_d = ST_END2;
            end
            ST_END2: begin
                cg_nxt  = CG_END2;
                state_d = ST_IDLE;
            end
            default: begin
                cg_nxt  = CG_IDLE;
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/cg_pipe_reg.sv
`timescale 1ns/1ps
module cg_pipe_reg #(
    parameter int           W       = 5,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= RST_VAL;
        else     q <= d;
    end
endmodule

// File: rtl/tx_codegroup_framer.sv
`timescale 1ns/1ps
module tx_codegroup_framer
    import cg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_en,
    input  logic             tx_er,
    input  logic [NIB_W-1:0] txd,
    output logic [CG_W-1:0]  code_out
);
    mii_tx_s tx_in;
    cg_t     data_cg;
    cg_t     cg_nxt;

    assign tx_in = '{en: tx_en, er: tx_er, d: txd};

    cg_data_map map_i (
        .nib  (tx_in.d),
        .code (data_cg)
    );

    cg_frame_seq seq_i (
        .clk     (clk),
        .rst     (rst),
        .tx      (tx_in),
        .data_cg (data_cg),
        .cg_nxt  (cg_nxt)
    );

    cg_pipe_reg #(.W(CG_W), .RST_VAL(CG_IDLE)) out_i (
        .clk (clk),
        .rst (rst),
        .d   (cg_nxt),
        .q   (code_out)
    );
endmodule

// File: rtl/cg_framer_chk.sv
`timescale 1ns/1ps
module cg_framer_chk
    import cg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             tx_en,
    input logic             tx_er,
    input logic [CG_W-1:0]  code_out
);
    logic body_cg;

    always_comb begin
        body_cg = (code_out == CG_HALT);
        for (int i = 0; i < NIB_VALUES; i++) begin
            if (code_out == nib_to_cg(i[NIB_W-1:0])) body_cg = 1'b1;
        end
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (code_out == CG_IDLE && !tx_en) |=> code_out == CG_IDLE);

    // R3
    start_j_chk: assert property (@(posedge clk) disable iff (rst)
        (code_out == CG_IDLE && tx_en) |=> code_out == CG_SSD1);

    // R3
    j_then_k_chk: assert property (@(posedge clk) disable iff (rst)
        code_out == CG_SSD1 |=> code_out == CG_SSD2);

    // R4
    t_then_r_chk: assert property (@(posedge clk) disable iff (rst)
        code_out == CG_END1 |=> code_out == CG_END2);

    // R4
    r_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
        code_out == CG_END2 |=> (code_out == CG_IDLE || code_out == CG_SSD1));

    // R5
    halt_inject_chk: assert property (@(posedge clk) disable iff (rst)
        (body_cg && tx_en && tx_er) |=> code_out == CG_HALT);

    // R9
    k_no_idle_chk: assert property (@(posedge clk) disable iff (rst)
        code_out == CG_SSD2 |=> (code_out != CG_IDLE && code_out != CG_SSD1));

    // R8
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> code_out == CG_IDLE);
endmodule

bind tx_codegroup_framer cg_framer_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .tx_en    (tx_en),
    .tx_er    (tx_er),
    .code_out (code_out)
);

// File: tb/tx_codegroup_framer_tb_top.sv
`timescale 1ns/1ps
module tx_codegroup_framer_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_en = 1'b0;
    logic       tx_er = 1'b0;
    logic [3:0] txd = 4'h0;
    logic [4:0] code_out;

    int checks = 0;
    int errors = 0;

    logic [4:0] exp_q[$];
    string      tag_q[$];

    localparam logic [4:0] I_CG = 5'b11111;
    localparam logic [4:0] J_CG = 5'b11000;
    localparam logic [4:0] K_CG = 5'b10001;
    localparam logic [4:0] T_CG = 5'b01101;
    localparam logic [4:0] R_CG = 5'b00111;
    localparam logic [4:0] H_CG = 5'b00100;

    always #5 clk = ~clk;

    tx_codegroup_framer dut_i (
        .clk      (clk),
        .rst      (rst),
        .tx_en    (tx_en),
        .tx_er    (tx_er),
        .txd      (txd),
        .code_out (code_out)
    );

    function automatic logic [4:0] ref_cg(input logic [3:0] n);
        logic [4:0] t[16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                              5'b01010, 5'b01011, 5'b01110, 5'b01111,
                              5'b10010, 5'b10011, 5'b10110, 5'b10111,
                              5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return t[n];
    endfunction

    task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    // monitor: compares one queued item per clock, after the edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [4:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, code_out, e);
        end
    end

    task automatic drive(input logic en, input logic er, input logic [3:0] d,
                         input logic [4:0] exp, input string tag);
        @(negedge clk);
        tx_en = en;
        tx_er = er;
        txd   = d;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++)
            drive(1'b0, i[0], 4'(i * 7), I_CG, "R2/R6 idle");
    endtask

    task automatic frame(input int len, input logic [3:0] base,
                         input int err_at, input logic pre_er);
        drive(1'b1, pre_er, 4'h5, J_CG, pre_er ? "R10 J" : "R3 J");
        drive(1'b1, pre_er, 4'h5, K_CG, pre_er ? "R10 K" : "R3 K");
        for (int i = 0; i < len; i++) begin
            logic [3:0] n;
            n = base + 4'(i);
            if (i == err_at) drive(1'b1, 1'b1, n, H_CG, "R5 halt");
            else             drive(1'b1, 1'b0, n, ref_cg(n), "R1 data");
        end
        drive(1'b0, 1'b1, ~base, T_CG, "R4 T");
        drive(1'b0, 1'b1, 4'hA, R_CG, "R4/R6 R");
        drive(1'b0, 1'b1, 4'h3, I_CG, "R4 back to idle");
    endtask

    task automatic drain;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R8: reset state
        repeat (2) @(negedge clk);
        check("R8 during reset", code_out, I_CG);
        rst = 1'b0;
        @(negedge clk);
        check("R8 after reset", code_out, I_CG);

        idle(4);
        frame(4, 4'h0, -1, 1'b0);
        frame(16, 4'h0, -1, 1'b0);
        frame(6, 4'h9, 2, 1'b0);
        frame(3, 4'hC, 2, 1'b0);
        frame(2, 4'h7, -1, 1'b1);
        idle(1);

        // R9: enable held for one nibble only
        drive(1'b1, 1'b0, 4'h5, J_CG, "R9 J");
        drive(1'b0, 1'b1, 4'hF, K_CG, "R9 K");
        drive(1'b0, 1'b0, 4'h1, T_CG, "R9 T");
        drive(1'b0, 1'b1, 4'h2, R_CG, "R9 R");
        drive(1'b0, 1'b0, 4'h0, I_CG, "R9 idle");

        // R9: enable held for two nibbles, no body
        drive(1'b1, 1'b0, 4'h5, J_CG, "R9 J2");
        drive(1'b1, 1'b0, 4'h5, K_CG, "R9 K2");
        drive(1'b0, 1'b1, 4'h9, T_CG, "R9 T2");
        drive(1'b0, 1'b0, 4'h6, R_CG, "R9 R2");
        drive(1'b0, 1'b0, 4'h0, I_CG, "R9 idle2");
        drain();

        // R7: output holds until the edge after the input changes
        drive(1'b1, 1'b0, 4'h5, J_CG, "R7 J after edge");
        #1;
        check("R7 no change before edge", code_out, I_CG);
        drive(1'b1, 1'b0, 4'h5, K_CG, "R7 K");
        drive(1'b1, 1'b0, 4'h3, ref_cg(4'h3), "R7 data");
        drive(1'b0, 1'b0, 4'h0, T_CG, "R7 T");
        drive(1'b0, 1'b0, 4'h0, R_CG, "R7 R");
        drive(1'b0, 1'b0, 4'h0, I_CG, "R7 idle");
        drain();

        // R8: reset in the middle of a frame
        drive(1'b1, 1'b0, 4'h5, J_CG, "R8 J pre-reset");
        drive(1'b1, 1'b0, 4'h5, K_CG, "R8 K pre-reset");
        @(negedge clk);
        rst = 1'b1;
        tx_en = 1'b1;
        txd = 4'h4;
        @(negedge clk);
        check("R8 mid-frame reset", code_out, I_CG);
        tx_en = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R8 idle after reset", code_out, I_CG);
        frame(2, 4'hE, -1, 1'b0);
        idle(2);
        drain();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule